// File: doc/BRIEF.md
# Serial Configuration Port with Register Readback

This block is the control port of a configurable chip. A host drives three lines: a serial clock, a data line and a load strobe. Data bits are sampled on rising serial clock edges, least significant bit first, into a 32-bit shift register. When the load strobe rises, the shifted word is committed to one of the configuration registers. The low five bits of the word carry the target address. The committed register contents appear on a flat parallel output so that the controlled logic can use them.

All three host lines are brought into the system clock domain through a synchronizer, and each of their edges becomes a single-cycle event. Register 0 is not storage. It is a command slot: a word aimed at it with its top bit set starts a readback. In a readback, the first serial clock after the strobe does nothing. Each of the next 32 clocks then presents one bit of the chosen register on a dedicated output, least significant bit first. Selecting register 0 returns a status word built from live inputs and a fixed identifier. A calibration-start flag in register 2 drops back to zero on its own one cycle after it is written as one.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, registers 1 to 7 hold 0x41500029, 0x08A0100A, 0x0000000B, 0x4A01F00C, 0x0A2AA28D, 0x0000000E and 0x0000000F, and the readback output is low.
- R2: A word is shifted in LSB first, one bit per rising serial clock. On the rising load strobe it is written whole into register N when bits [4:3] are 01 and bits [2:0] equal N (1 to 7). Register N appears on `cfg_flat[(N-1)*32 +: 32]`.
- R3: A word whose bits [4:3] are not 01 changes no register.
- R4: A word with bits [4:0] = 01000 and bit 31 = 1 starts a readback of the register chosen by bits [30:28]. The first rising serial clock after the strobe leaves the output unchanged. Each of the next 32 rising clocks drives the next bit of that register onto `rdbk_out`, bit 0 first, and the bit is held through the following falling edge.
- R5: A readback of register 0 returns bits 6 and 5 as 1 and 1, bit 12 as `cal_err`, bits [30:13] as `cal_stat`, and zero in every other bit. The inputs are sampled at the strobe.
- R6: Bit 31 of register 2 is high for exactly one system clock cycle after it is written as 1, and then reads back as 0.
- R7: After the 32nd readback bit the port returns to idle. The next rising serial clock drives `rdbk_out` low.
- R8: Each rising edge of the load strobe performs exactly one write. While the strobe stays high, further shifting does not change any register.
- R9: A register-0 word with bit 31 = 0 starts no readback and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock |
| ser_data | input | 1 | Host serial data, LSB first |
| ser_le | input | 1 | Host load strobe, commits on its rising edge |
| cal_err | input | 1 | Calibration error flag returned in the register-0 readback |
| cal_stat | input | 18 | Counter or calibration result returned in the register-0 readback |
| rdbk_out | output | 1 | Serial readback data |
| cfg_flat | output | 224 | Registers 1 to 7 side by side, register 1 in the low bits |

## Verification
A corrupted shift register or a wrong address decode shows up on `cfg_flat` within a few system cycles of the strobe edge: the wrong slice changes, or a slice changes when none should. A wrong readback sequence shows up on `rdbk_out` at the first serial clock after the strobe. An idle clock that is not idle appears one bit early, and a stuck counter shows as a non-zero bit on the 33rd clock. A broken self-clear on the calibration flag shows as a high time other than one cycle, or as a 1 in the register-2 readback.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int WORD_W   = 32;
  localparam int NREG     = 8;
  localparam int IDX_W    = $clog2(NREG);
  localparam int STAT_W   = 18;
  localparam int CAL_REG  = 2;
  localparam int CAL_BIT  = 31;
  localparam int CNT_W    = $clog2(WORD_W);

  localparam logic [4:0] CMD_ADDR = 5'b01000;
  localparam logic [1:0] ID_BITS  = 2'b11;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_WAIT  = 2'd1,
    RB_SHIFT = 2'd2
  } rb_state_t;

  function automatic word_t reset_word(input int unsigned idx);
    case (idx)
      1:       return 32'h4150_0029;
      2:       return 32'h08A0_100A;
      4:       return 32'h4A01_F00C;
      5:       return 32'h0A2A_A28D;
      default: return {27'd0, 2'b01, 3'(idx)};
    endcase
  endfunction
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift
  import serial_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  shift_en,
  input  logic  din,
  output word_t word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {din, word[WORD_W-1:1]};
  end
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
  import serial_cfg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld,
  input  word_t                         word_in,
  input  logic [IDX_W-1:0]              rd_sel,
  output word_t                         rd_word,
  output logic [(NREG-1)*WORD_W-1:0]    cfg_flat
);
  logic [NREG-1:1][WORD_W-1:0] regs;
  logic [IDX_W-1:0]            idx;
  logic                        hit;

  assign idx = word_in[IDX_W-1:0];
  assign hit = (word_in[4:3] == 2'b01) && (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < NREG; k++) regs[k] <= reset_word(k);
    end else begin
      if (regs[CAL_REG][CAL_BIT]) regs[CAL_REG][CAL_BIT] <= 1'b0;
      if (ld && hit) regs[idx] <= word_in;
    end
  end

  assign rd_word  = (rd_sel == '0) ? '0 : regs[rd_sel];
  assign cfg_flat = regs;

  AST_CAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    regs[CAL_REG][CAL_BIT] |=> !regs[CAL_REG][CAL_BIT]); // R6

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ld && word_in[4:3] != 2'b01 && !regs[CAL_REG][CAL_BIT]) |=> $stable(regs)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (ld && word_in[4:0] == 5'b01111) |=> (regs[7] == $past(word_in))); // R2
endmodule

// File: rtl/serial_cfg_readback.sv
module serial_cfg_readback
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [IDX_W-1:0]  sel,
  input  word_t             bank_word,
  input  logic              cal_err,
  input  logic [STAT_W-1:0] cal_stat,
  input  logic              sclk_rise,
  output logic              rdbk
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rb_state_t        st;
  word_t            snap;
  word_t            stat_word;
  logic [CNT_W-1:0] cnt;

  assign stat_word = {1'b0, cal_stat, cal_err, 5'b0, ID_BITS, 5'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RB_IDLE;
      snap <= '0;
      cnt  <= '0;
      rdbk <= 1'b0;
    end else if (arm) begin
      st   <= RB_WAIT;
      snap <= (sel == '0) ? stat_word : bank_word;
      cnt  <= '0;
    end else if (sclk_rise) begin
      case (st)
        RB_IDLE:  rdbk <= 1'b0;
        RB_WAIT:  st   <= RB_SHIFT;
        RB_SHIFT: begin
          rdbk <= snap[0];
          snap <= {1'b0, snap[WORD_W-1:1]};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) st <= RB_IDLE;
        end
        default:  st <= RB_IDLE;
      endcase
    end
  end

  AST_RB_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == RB_IDLE && sclk_rise && !arm) |=> !rdbk); // R7

  AST_RB_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == RB_WAIT && sclk_rise && !arm) |=> $stable(rdbk)); // R4
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ser_clk,
  input  logic                          ser_data,
  input  logic                          ser_le,
  input  logic                          cal_err,
  input  logic [STAT_W-1:0]             cal_stat,
  output logic                          rdbk_out,
  output logic [(NREG-1)*WORD_W-1:0]    cfg_flat
);
  logic [2:0] sq;
  logic       sclk_q, le_q;
  logic       sclk_rise, le_rise;
  word_t      sh_word;
  word_t      bank_word;
  logic       rb_arm;

  serial_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_le, ser_data, ser_clk}),
    .q   (sq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sq[0];
      le_q   <= sq[2];
    end
  end

  assign sclk_rise = sq[0] & ~sclk_q;
  assign le_rise   = sq[2] & ~le_q;

  serial_cfg_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .din      (sq[1]),
    .word     (sh_word)
  );

  assign rb_arm = le_rise && (sh_word[4:0] == CMD_ADDR) && sh_word[WORD_W-1];

  serial_cfg_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .ld       (le_rise),
    .word_in  (sh_word),
    .rd_sel   (sh_word[WORD_W-2 -: IDX_W]),
    .rd_word  (bank_word),
    .cfg_flat (cfg_flat)
  );

  serial_cfg_readback u_rb (
    .clk       (clk),
    .rst       (rst),
    .arm       (rb_arm),
    .sel       (sh_word[WORD_W-2 -: IDX_W]),
    .bank_word (bank_word),
    .cal_err   (cal_err),
    .cal_stat  (cal_stat),
    .sclk_rise (sclk_rise),
    .rdbk      (rdbk_out)
  );

  AST_LE_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    le_rise |=> !le_rise); // R8
endmodule

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic         cal_err = 1'b0;
  logic [17:0]  cal_stat = '0;
  logic         rdbk_out;
  logic [223:0] cfg_flat;

  int nchk = 0, nerr = 0, cal_hi = 0;
  bit done = 0;
  string cur_req = "R4";
  logic exp_q[$];
  event mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .cal_err(cal_err), .cal_stat(cal_stat), .rdbk_out(rdbk_out), .cfg_flat(cfg_flat)
  );

  always @(posedge clk) if (!rst && cfg_flat[63]) cal_hi++;

  function automatic logic [31:0] rst_val(int k);
    case (k)
      1: return 32'h41500029; 2: return 32'h08A0100A; 3: return 32'h0000000B;
      4: return 32'h4A01F00C; 5: return 32'h0A2AA28D; 6: return 32'h0000000E;
      default: return 32'h0000000F;
    endcase
  endfunction

  function automatic logic [31:0] reg_of(int k);
    return cfg_flat[(k-1)*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected readback bit per marked falling edge
  initial forever begin
    @(mon_ev);
    nchk++;
    if (exp_q.size() == 0) begin
      nerr++;
      $display("FAIL %s actual=%b expected=<none>", cur_req, rdbk_out);
    end else begin
      logic e;
      e = exp_q.pop_front();
      if (rdbk_out !== e) begin
        nerr++;
        $display("FAIL %s actual=%b expected=%b", cur_req, rdbk_out, e);
      end
    end
  end

  task automatic pulse(logic b, bit fire);
    ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (6) @(negedge clk);
    ser_clk = 1'b0;
    if (fire) -> mon_ev;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_only(logic [31:0] w);
    for (int i = 0; i < 32; i++) pulse(w[i], 0);
  endtask

  task automatic latch();
    ser_le = 1'b1;
    repeat (6) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] w);
    shift_only(w);
    latch();
  endtask

  task automatic do_readback(logic [2:0] sel, logic [31:0] exp, string tag);
    cur_req = tag;
    for (int i = 0; i < 32; i++) exp_q.push_back(exp[i]);
    send_word({1'b1, sel, 28'h0000008});
    pulse(1'b0, 0);                         // idle clock, R4
    for (int i = 0; i < 32; i++) pulse(1'b0, 1);
    chk({tag, " queue"}, exp_q.size(), 0);
    pulse(1'b0, 0);
    chk("R7 rdbk low after end", {31'd0, rdbk_out}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset values
    for (int k = 1; k < 8; k++) chk("R1 reset", reg_of(k), rst_val(k));
    chk("R1 rdbk reset", {31'd0, rdbk_out}, 32'd0);
    do_readback(3'd1, rst_val(1), "R1/R4 readback reg1");

    // R2 writes
    send_word(32'h123456EB);
    chk("R2 reg3", reg_of(3), 32'h123456EB);
    send_word(32'hDEADBEEF);
    chk("R2 reg7", reg_of(7), 32'hDEADBEEF);
    chk("R2 reg6 untouched", reg_of(6), rst_val(6));
    do_readback(3'd3, 32'h123456EB, "R4 readback reg3");

    // R3 bad addresses
    send_word(32'hFFFFFFF3);
    send_word(32'h00000007);
    chk("R3 reg3", reg_of(3), 32'h123456EB);
    chk("R3 reg7", reg_of(7), 32'hDEADBEEF);
    chk("R3 reg1", reg_of(1), rst_val(1));
    do_readback(3'd7, 32'hDEADBEEF, "R3/R4 readback reg7");

    // R6 self-clearing calibration bit
    cal_hi = 0;
    send_word(32'h80A0100A);
    chk("R6 high cycles", cal_hi, 1);
    chk("R6 reg2", reg_of(2), 32'h00A0100A);
    do_readback(3'd2, 32'h00A0100A, "R6 readback reg2");

    // R5 register 0 status readback
    cal_err = 1'b1;
    cal_stat = 18'h2B3C5;
    r0 = {1'b0, 18'h2B3C5, 1'b1, 5'b0, 2'b11, 5'b0};
    do_readback(3'd0, r0, "R5 readback reg0");
    cal_err = 1'b0;
    cal_stat = 18'h00001;
    do_readback(3'd0, 32'h00002060, "R5 readback reg0 b");

    // R9 register-0 word without the readback bit
    send_word(32'h70000008);
    for (int i = 0; i < 34; i++) begin
      pulse(1'b0, 0);
      chk("R9 rdbk idle", {31'd0, rdbk_out}, 32'd0);
    end
    chk("R9 reg7", reg_of(7), 32'hDEADBEEF);

    // R8 one load per strobe rise
    send_word(32'h0000A5CE);
    chk("R8 first load", reg_of(6), 32'h0000A5CE);
    ser_le = 1'b1;
    repeat (6) @(negedge clk);
    shift_only(32'h5A5A00EE);
    chk("R8 held strobe", reg_of(6), 32'h0000A5CE);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 after fall", reg_of(6), 32'h0000A5CE);
    latch();
    chk("R8 new rise", reg_of(6), 32'h5A5A00EE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule